// File: doc/BRIEF.md
# Load-Use Stall Controller

This block guards a five-stage in-order pipeline against the one data hazard that result forwarding cannot repair. A load produces its value only after the memory stage. An instruction directly behind it that reads the loaded register would therefore enter execute one cycle too early. The controller compares the register a load in execute will write against the two source registers of the instruction in decode. When they match, it holds that instruction back for one cycle.

The stall has three parts. The program counter keeps its value. The fetch/decode latch keeps its instruction. A zero control word enters the decode/execute register in place of the decoded one, which forms a bubble. On the next cycle the bubble occupies execute, the hazard condition is false, and the pipeline moves on. Software does not need to pad code with no-ops.

The project contains the detector plus enough of the pipeline front to exercise it: the program counter, the fetch/decode latch, a small main-control decoder, and the control and destination fields of the decode/execute register. Instruction words arrive on a plain input from the instruction memory. The block has no handshake: one word is presented every cycle at the address on `pc_o`.

Top module: `ldu_stall_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `pc_o` is 0, `idex_ctrl_o` is all zeros, and `pc_we_o`/`ifid_we_o` are 1 with `bubble_o` 0.
- R2: The stall is raised when the decode/execute control word has its memory-read bit set and its destination equals the Rs field (instr[25:21]) of the instruction in the fetch/decode latch, with that destination nonzero.
- R3: The stall is raised under the same conditions when the destination equals the Rt field (instr[20:16]) of the latched instruction.
- R4: A load whose destination is register 0 never raises a stall, even when it matches a source field.
- R5: When the memory-read bit in the decode/execute register is clear, a register match raises no stall.
- R6: In a stall cycle `pc_we_o` and `ifid_we_o` are 0, and at the next edge `pc_o` and `ifid_instr_o` keep their values.
- R7: In a stall cycle `bubble_o` is 1, and at the next edge `idex_ctrl_o` becomes all zeros.
- R8: A stall lasts exactly one cycle. The cycle after a stall is never a stall.
- R9: Outside a stall, `pc_o` advances by 4 at each edge and the fetch/decode latch captures `instr_i`.
- R10: Outside a stall, `idex_ctrl_o` takes the decode of the latched opcode (instr[31:26]). The 9-bit word is {regdst, alusrc, aluop[1:0], memread, memwrite, branch, regwrite, memtoreg}, bit 8 down to bit 0. The opcode values decode as follows: 0x23 gives 0_1_00_1_0_0_1_1, 0x2B gives 0_1_00_0_1_0_0_0, 0x00 gives 1_0_10_0_0_0_1_0, 0x04 gives 0_0_01_0_0_1_0_0, and any other opcode gives all zeros. `idex_rt_o` always takes the latched Rt field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 32 | Instruction word fetched at `pc_o` |
| pc_o | output | 32 | Program counter |
| ifid_instr_o | output | 32 | Instruction held in the fetch/decode latch |
| idex_ctrl_o | output | 9 | Control word in the decode/execute register |
| idex_rt_o | output | 5 | Rt / load destination in the decode/execute register |
| pc_we_o | output | 1 | PC update enable, low only during a stall |
| ifid_we_o | output | 1 | Fetch/decode latch enable, low only during a stall |
| bubble_o | output | 1 | Clears the control word entering decode/execute |

## Verification
The assertions assume that `instr_i` carries a known value on every clock edge and that reset is applied synchronously for at least one edge. From those two facts they treat the pipeline state as always defined. The one-cycle-stall property also relies on the decoder producing a zero memory-read bit in a bubble. The stimulus keeps to these assumptions: it drives a defined word at every falling edge and uses only the four listed opcodes plus one unused value. Register fields are drawn from 0 to 3, so matches, including matches on register 0, occur often.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  localparam int XLEN    = 32;
  localparam int RA_W    = 5;
  localparam int OP_W    = 6;
  localparam int OP_LSB  = 26;
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;

  localparam logic [OP_W-1:0] OPC_LOAD   = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE  = 6'h2B;
  localparam logic [OP_W-1:0] OPC_ALU    = 6'h00;
  localparam logic [OP_W-1:0] OPC_BRANCH = 6'h04;

  typedef struct packed {
    logic       regdst;
    logic       alusrc;
    logic [1:0] aluop;
  } ex_ctl_t;

  typedef struct packed {
    logic memread;
    logic memwrite;
    logic branch;
  } mem_ctl_t;

  typedef struct packed {
    logic regwrite;
    logic memtoreg;
  } wb_ctl_t;

  typedef struct packed {
    ex_ctl_t  ex;
    mem_ctl_t mem;
    wb_ctl_t  wb;
  } ctl_word_t;

  localparam int CTL_W = $bits(ctl_word_t);

  function automatic ctl_word_t decode_op(input logic [OP_W-1:0] op);
    ctl_word_t c;
    c = '0;
    unique case (op)
      OPC_LOAD:   begin c.ex.alusrc = 1'b1; c.mem.memread = 1'b1;
                        c.wb.regwrite = 1'b1; c.wb.memtoreg = 1'b1; end
      OPC_STORE:  begin c.ex.alusrc = 1'b1; c.mem.memwrite = 1'b1; end
      OPC_ALU:    begin c.ex.regdst = 1'b1; c.ex.aluop = 2'b10;
                        c.wb.regwrite = 1'b1; end
      OPC_BRANCH: begin c.ex.aluop = 2'b01; c.mem.branch = 1'b1; end
      default:    c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/ldu_hazard_detect.sv
module ldu_hazard_detect #(
  parameter int RA_W = 5,
  parameter int NSRC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load_in_ex_i,
  input  logic [RA_W-1:0]           load_dst_i,
  input  logic [NSRC-1:0][RA_W-1:0] src_i,
  output logic                      stall_o
);
  logic [NSRC-1:0] hit;
  logic            dst_live;

  assign dst_live = (load_dst_i != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src_cmp
    assign hit[g] = (src_i[g] == load_dst_i);
  end

  assign stall_o = load_in_ex_i && dst_live && (|hit);

  // R5: with no load in execute the unit never stalls
  p_no_load_no_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_in_ex_i |-> !stall_o);
  // R4: register 0 as load destination never stalls
  p_zero_dst_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_dst_i == '0) |-> !stall_o);
endmodule

// File: rtl/ldu_fetch.sv
module ldu_fetch #(
  parameter int XLEN    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold_i,
  input  logic [XLEN-1:0] instr_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] ifid_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  logic [XLEN-1:0] pc_q, ifid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      ifid_q <= '0;
    end else if (!hold_i) begin
      pc_q   <= pc_q + STEP;
      ifid_q <= instr_i;
    end
  end

  assign pc_o   = pc_q;
  assign ifid_o = ifid_q;

  // R6: a held cycle freezes PC and latch
  p_hold_freezes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> ($stable(pc_q) && $stable(ifid_q)));
  // R9: a free cycle steps the PC
  p_pc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_i |=> (pc_q == $past(pc_q) + STEP));
endmodule

// File: rtl/ldu_idex_ctrl.sv
module ldu_idex_ctrl
  import ldu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bubble_i,
  input  logic [XLEN-1:0] ifid_i,
  output ctl_word_t       ctrl_o,
  output logic [RA_W-1:0] rt_o
);
  ctl_word_t       ctrl_q, ctrl_d;
  logic [RA_W-1:0] rt_q;

  always_comb begin
    ctrl_d = decode_op(ifid_i[OP_LSB +: OP_W]);
    if (bubble_i) ctrl_d = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rt_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      rt_q   <= ifid_i[RT_LSB +: RA_W];
    end
  end

  assign ctrl_o = ctrl_q;
  assign rt_o   = rt_q;

  // R7: a bubble leaves an all-zero control word
  p_bubble_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_i |=> (ctrl_q == '0));
endmodule

// File: rtl/ldu_stall_top.sv
module ldu_stall_top
  import ldu_pkg::*;
#(
  parameter int PC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [XLEN-1:0]  instr_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  ifid_instr_o,
  output logic [CTL_W-1:0] idex_ctrl_o,
  output logic [RA_W-1:0]  idex_rt_o,
  output logic             pc_we_o,
  output logic             ifid_we_o,
  output logic             bubble_o
);
  localparam int NSRC = 2;

  logic                      stall;
  logic [XLEN-1:0]           ifid;
  ctl_word_t                 idex_ctrl;
  logic [RA_W-1:0]           idex_rt;
  logic [NSRC-1:0][RA_W-1:0] srcs;

  assign srcs[0] = ifid[RS_LSB +: RA_W];
  assign srcs[1] = ifid[RT_LSB +: RA_W];

  ldu_hazard_detect #(.RA_W(RA_W), .NSRC(NSRC)) u_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_in_ex_i (idex_ctrl.mem.memread),
    .load_dst_i   (idex_rt),
    .src_i        (srcs),
    .stall_o      (stall)
  );

  ldu_fetch #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (stall),
    .instr_i (instr_i),
    .pc_o    (pc_o),
    .ifid_o  (ifid)
  );

  ldu_idex_ctrl #(.XLEN(XLEN)) u_idex (
    .clk      (clk),
    .rst_n    (rst_n),
    .bubble_i (stall),
    .ifid_i   (ifid),
    .ctrl_o   (idex_ctrl),
    .rt_o     (idex_rt)
  );

  assign ifid_instr_o = ifid;
  assign idex_ctrl_o  = idex_ctrl;
  assign idex_rt_o    = idex_rt;
  assign pc_we_o      = !stall;
  assign ifid_we_o    = !stall;
  assign bubble_o     = stall;

  // R8: never two stall cycles in a row
  p_single_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);
  // R2/R3: a stall implies the latched instruction reads the load target
  p_stall_has_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (idex_rt == ifid[RS_LSB +: RA_W] || idex_rt == ifid[RT_LSB +: RA_W]));
endmodule

// File: tb/ldu_stall_top_tb_top.sv
module ldu_stall_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] pc_o, ifid_instr_o;
  logic [8:0]  idex_ctrl_o;
  logic [4:0]  idex_rt_o;
  logic        pc_we_o, ifid_we_o, bubble_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_pc, m_ifid;
  logic [8:0]  m_ctrl;
  logic [4:0]  m_rt;
  bit          prev_stall;

  always #5 clk = ~clk;

  ldu_stall_top dut_i (.*);

  function automatic logic [8:0] exp_ctrl(input logic [5:0] op);
    case (op)
      6'h23: return 9'b0_1_00_1_0_0_1_1;
      6'h2B: return 9'b0_1_00_0_1_0_0_0;
      6'h00: return 9'b1_0_10_0_0_0_1_0;
      6'h04: return 9'b0_0_01_0_0_1_0_0;
      default: return 9'b0;
    endcase
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rs,
                                     input logic [4:0] rt, input logic [4:0] rd);
    return {op, rs, rt, rd, 11'd0};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: check current state at the falling edge, then drive and advance
  task automatic step(input logic [31:0] w);
    bit rd, hs, ht, st;
    string stag;
    rd = m_ctrl[4];
    hs = (m_ifid[25:21] == m_rt);
    ht = (m_ifid[20:16] == m_rt);
    st = rd && (m_rt != 0) && (hs || ht);
    if (prev_stall)               stag = "R8";
    else if (st && hs)            stag = "R2";
    else if (st)                  stag = "R3";
    else if (rd && m_rt == 0 && (hs || ht)) stag = "R4";
    else if (!rd && (hs || ht))   stag = "R5";
    else                          stag = "R9";
    chk({stag, " stall"}, {61'd0, pc_we_o, ifid_we_o, bubble_o}, {61'd0, !st, !st, st});
    chk(prev_stall ? "R6 pc" : "R9 pc", 64'(pc_o), 64'(m_pc));
    chk(prev_stall ? "R6 ifid" : "R9 ifid", 64'(ifid_instr_o), 64'(m_ifid));
    chk(prev_stall ? "R7 ctrl" : "R10 ctrl", 64'(idex_ctrl_o), 64'(m_ctrl));
    chk("R10 rt", 64'(idex_rt_o), 64'(m_rt));
    instr_i = w;
    m_ctrl = st ? 9'd0 : exp_ctrl(m_ifid[31:26]);
    m_rt   = m_ifid[20:16];
    if (!st) begin
      m_pc   = m_pc + 32'd4;
      m_ifid = w;
    end
    prev_stall = st;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [5:0] ops [5];
    ops = '{6'h23, 6'h2B, 6'h00, 6'h04, 6'h3F};
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 pc", 64'(pc_o), 64'd0);
    chk("R1 ctrl", 64'(idex_ctrl_o), 64'd0);
    chk("R1 we", {62'd0, pc_we_o, bubble_o}, 64'd2);
    rst_n = 1'b1;
    m_pc = '0; m_ifid = '0; m_ctrl = '0; m_rt = '0; prev_stall = 1'b0;
    // first cycle after reset: state unchanged (R1)
    chk("R1 post pc", 64'(pc_o), 64'd0);
    chk("R1 post ctrl", 64'(idex_ctrl_o), 64'd0);
    // directed: load r7, then use as Rs (R2)
    step(mk(6'h23, 5'd1, 5'd7, 5'd0));
    step(mk(6'h00, 5'd7, 5'd2, 5'd9));
    step(mk(6'h00, 5'd3, 5'd4, 5'd5));
    step(mk(6'h00, 5'd3, 5'd4, 5'd5));
    step(mk(6'h00, 5'd3, 5'd4, 5'd5));
    // load r6, then use as Rt (R3)
    step(mk(6'h23, 5'd1, 5'd6, 5'd0));
    step(mk(6'h2B, 5'd2, 5'd6, 5'd0));
    step(mk(6'h04, 5'd8, 5'd9, 5'd0));
    step(mk(6'h04, 5'd8, 5'd9, 5'd0));
    // load to r0, then read r0 (R4)
    step(mk(6'h23, 5'd1, 5'd0, 5'd0));
    step(mk(6'h00, 5'd0, 5'd0, 5'd3));
    step(mk(6'h00, 5'd1, 5'd2, 5'd3));
    // non-load writing r5 then reader (R5)
    step(mk(6'h00, 5'd1, 5'd5, 5'd5));
    step(mk(6'h00, 5'd5, 5'd5, 5'd4));
    step(mk(6'h3F, 5'd1, 5'd2, 5'd3));
    step(mk(6'h3F, 5'd1, 5'd2, 5'd3));
    // random mix with narrow register range
    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      op = ops[$urandom_range(4, 0)];
      step(mk(op, 5'($urandom_range(3, 0)), 5'($urandom_range(3, 0)),
              5'($urandom_range(3, 0))));
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule